// File: doc/BRIEF.md
# CPU exception entry controller

This block performs the entry half of exception handling for a simple 32-bit RISC core. A pipeline raises a one-cycle `take` strobe with a cause code, the PC of the instruction involved and a flag saying whether that instruction sat in a branch delay slot. External and timer interrupt lines are sampled every cycle in which no strobe is present. Each one is eligible only while its enable bit in the status register is set.

When an event is accepted, the block saves a return PC and the pre-exception status word. For illegal instructions it also saves the faulting address. In that same clock edge it switches the status word to supervisor mode with translation and interrupts off, clears the power-saving enables, kills any load-link reservation, and emits the handler address on `redirect_pc` with a one-cycle `redirect` pulse. A cause code outside 1..14 produces a one-cycle `unhandled` pulse and changes no saved state.

Cause codes: 1 reset, 2 bus error, 3 data protection fault, 4 instruction protection fault, 5 tick timer, 6 alignment, 7 illegal instruction, 8 external interrupt, 9 data TLB miss, 10 instruction TLB miss, 11 range, 12 system call, 13 floating point, 14 trap. Status word bits: 0 supervisor, 1 tick enable, 2 interrupt enable, 3 data MMU enable, 4 instruction MMU enable, 5 high vector page, 6 delay-slot exception.

Top module: `exc_entry`

## Requirements
- R1: While synchronous reset is high, and on the first cycle after it: `epc`, `eea` and `esr` are 0, `sr` is 0x0001 (supervisor only), `pm_en` is 0, `lock_addr` is all ones, `redirect_pc` is 0x100, and `redirect`, `unhandled` and `dslot_clr` are 0.
- R2: On entry, `epc` takes the event PC, or the event PC + 4 when the cause is 12 (system call).
- R3: On entry from a delay slot (`in_dslot`=1), 4 is subtracted from the value given by R2, status bit 6 is set and `dslot_clr` pulses for one cycle. Otherwise status bit 6 is cleared.
- R4: Cause 7 (illegal) loads `eea` with the event PC. Every other cause leaves `eea` unchanged.
- R5: On entry, `esr` takes the status word held before the event. The status word then clears bits 1, 2, 3 and 4, sets bit 0 and keeps bit 5.
- R6: On entry, `pm_en` becomes 0 and `lock_addr` becomes all ones.
- R7: The handler address is cause<<8. `evbar` is OR-ed in when `vbar_en`=1, and 0xF0000000 is OR-ed in when status bit 5 is set. The address appears on `redirect_pc` together with a one-cycle `redirect` pulse, one clock after the event.
- R8: A `take` with cause 0 or cause 15 pulses `unhandled` one clock later. It asserts no `redirect` and leaves `epc`, `eea`, `esr`, `sr`, `pm_en` and `lock_addr` unchanged.
- R9: With no `take`, `irq_ext` is taken as cause 8 only when status bit 2 is set. Otherwise it has no effect.
- R10: With no `take`, `irq_tick` is taken as cause 5 only when status bit 1 is set. When both interrupts are eligible, cause 5 is taken.
- R11: A `take` with a valid cause wins over any eligible interrupt in the same cycle. An entry wins over `sr_load`, `pm_load` and `lock_set` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| take | input | 1 | One-cycle exception strobe |
| cause | input | 4 | Exception cause code |
| cur_pc | input | 32 | PC of the instruction involved |
| in_dslot | input | 1 | Instruction was in a delay slot |
| irq_ext | input | 1 | External interrupt pending |
| irq_tick | input | 1 | Timer interrupt pending |
| vbar_en | input | 1 | Vector-base support present |
| evbar | input | 32 | Vector base address |
| sr_load | input | 1 | Write `sr_load_val` into the status word |
| sr_load_val | input | 16 | New status word |
| pm_load | input | 1 | Write `pm_load_val` into the power-saving enables |
| pm_load_val | input | 2 | Doze (bit 0) and sleep (bit 1) enables |
| lock_set | input | 1 | Record a load-link reservation |
| lock_set_addr | input | 32 | Reservation address |
| redirect | output | 1 | One-cycle pulse: fetch from `redirect_pc` |
| redirect_pc | output | 32 | Handler address |
| epc | output | 32 | Saved return PC |
| eea | output | 32 | Saved effective address |
| esr | output | 16 | Saved status word |
| sr | output | 16 | Current status word |
| pm_en | output | 2 | Power-saving enables |
| lock_addr | output | 32 | Reservation address, all ones when none |
| dslot_clr | output | 1 | One-cycle pulse: clear the delay-slot flag |
| unhandled | output | 1 | One-cycle pulse: invalid cause code |

## Verification
The hardest case to reach is an interrupt arriving while both enables are set, because every entry clears those same enables. The stimulus therefore reloads the status word before each interrupt test and holds the interrupt lines for only one cycle. That makes a second, spurious entry visible as a mismatch. Delay-slot entries use a system call and an illegal instruction, so the +4 and −4 adjustments meet both alone and together. The vector test sets the high-page bit, a base value and a non-zero cause at once.

// File: rtl/exc_entry.sv
module exc_entry #(
  parameter int XLEN   = 32,
  parameter int CW     = 4,
  parameter int SR_W   = 16,
  parameter int VSHIFT = 8,
  parameter int NCAUSE = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic [CW-1:0]   cause,
  input  logic [XLEN-1:0] cur_pc,
  input  logic            in_dslot,
  input  logic            irq_ext,
  input  logic            irq_tick,
  input  logic            vbar_en,
  input  logic [XLEN-1:0] evbar,
  input  logic            sr_load,
  input  logic [SR_W-1:0] sr_load_val,
  input  logic            pm_load,
  input  logic [1:0]      pm_load_val,
  input  logic            lock_set,
  input  logic [XLEN-1:0] lock_set_addr,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_pc,
  output logic [XLEN-1:0] epc,
  output logic [XLEN-1:0] eea,
  output logic [SR_W-1:0] esr,
  output logic [SR_W-1:0] sr,
  output logic [1:0]      pm_en,
  output logic [XLEN-1:0] lock_addr,
  output logic            dslot_clr,
  output logic            unhandled
);
  localparam int B_SUP = 0, B_TEE = 1, B_IEE = 2, B_DME = 3, B_IME = 4, B_PFX = 5, B_DSX = 6;
  localparam logic [CW-1:0] C_TICK = CW'(5), C_ILL = CW'(7), C_EXT = CW'(8), C_SYS = CW'(12);
  localparam logic [XLEN-1:0] HI_PAGE  = {4'hF, {(XLEN-4){1'b0}}};
  localparam logic [XLEN-1:0] RST_VEC  = XLEN'(1) << VSHIFT;
  localparam logic [SR_W-1:0] SR_RST   = SR_W'(1) << B_SUP;
  localparam logic [SR_W-1:0] SR_CLR   = (SR_W'(1) << B_TEE) | (SR_W'(1) << B_IEE) |
                                         (SR_W'(1) << B_DME) | (SR_W'(1) << B_IME) |
                                         (SR_W'(1) << B_DSX);

  logic            cause_ok, tick_ok, ext_ok, enter, bad;
  logic [CW-1:0]   ecause;
  logic [XLEN-1:0] epc_base, epc_nxt, vec;
  logic [SR_W-1:0] sr_nxt;

  assign cause_ok = (cause != '0) && (int'(cause) <= NCAUSE);
  assign tick_ok  = irq_tick & sr[B_TEE];
  assign ext_ok   = irq_ext & sr[B_IEE];
  assign enter    = take ? cause_ok : (tick_ok | ext_ok);
  assign bad      = take & ~cause_ok;
  assign ecause   = take ? cause : (tick_ok ? C_TICK : C_EXT);

  assign epc_base = cur_pc + ((ecause == C_SYS) ? XLEN'(4) : XLEN'(0));
  assign epc_nxt  = in_dslot ? epc_base - XLEN'(4) : epc_base;

  assign vec = (XLEN'(ecause) << VSHIFT)
             | (vbar_en ? evbar : '0)
             | (sr[B_PFX] ? HI_PAGE : '0);

  assign sr_nxt = (sr & ~SR_CLR) | (SR_W'(1) << B_SUP) | (SR_W'(in_dslot) << B_DSX);

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect    <= 1'b0;
      redirect_pc <= RST_VEC;
      epc         <= '0;
      eea         <= '0;
      esr         <= '0;
      sr          <= SR_RST;
      pm_en       <= '0;
      lock_addr   <= '1;
      dslot_clr   <= 1'b0;
      unhandled   <= 1'b0;
    end else begin
      redirect  <= enter;
      dslot_clr <= enter & in_dslot;
      unhandled <= bad;
      if (enter) begin
        redirect_pc <= vec;
        epc         <= epc_nxt;
        esr         <= sr;
        sr          <= sr_nxt;
        pm_en       <= '0;
        lock_addr   <= '1;
        if (ecause == C_ILL) eea <= cur_pc;
      end else begin
        if (sr_load)  sr        <= sr_load_val;
        if (pm_load)  pm_en     <= pm_load_val;
        if (lock_set) lock_addr <= lock_set_addr;
      end
    end
  end

  a_r5_entry_status: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (sr[B_SUP] && !sr[B_IEE] && !sr[B_TEE] && !sr[B_DME] && !sr[B_IME]));

  a_r6_entry_clears: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (pm_en == 2'b00 && lock_addr == '1));

  a_r3_dslot_mark: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (sr[B_DSX] == dslot_clr));

  a_r7_vector_align: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (redirect_pc[VSHIFT-1:0] == '0));

  a_r8_bad_no_change: assert property (@(posedge clk) disable iff (rst)
    unhandled |-> (!redirect && $stable(epc) && $stable(eea) && $stable(esr)));

  a_r3_clr_only_on_entry: assert property (@(posedge clk) disable iff (rst)
    dslot_clr |-> redirect);
endmodule

// File: tb/exc_entry_bench.sv
module exc_entry_bench;
  logic clk = 0, rst = 1;
  always #10 clk = ~clk;

  logic take = 0, in_dslot = 0, irq_ext = 0, irq_tick = 0, vbar_en = 0;
  logic sr_load = 0, pm_load = 0, lock_set = 0;
  logic [3:0] cause = 0;
  logic [31:0] cur_pc = 0, evbar = 0, lock_set_addr = 0;
  logic [15:0] sr_load_val = 0;
  logic [1:0] pm_load_val = 0;
  logic redirect, dslot_clr, unhandled;
  logic [31:0] redirect_pc, epc, eea, lock_addr;
  logic [15:0] esr, sr;
  logic [1:0] pm_en;

  exc_entry u_exc_entry (.clk, .rst, .take, .cause, .cur_pc, .in_dslot, .irq_ext, .irq_tick,
    .vbar_en, .evbar, .sr_load, .sr_load_val, .pm_load, .pm_load_val, .lock_set, .lock_set_addr,
    .redirect, .redirect_pc, .epc, .eea, .esr, .sr, .pm_en, .lock_addr, .dslot_clr, .unhandled);

  typedef struct {
    logic rd; logic [31:0] rpc, epc, eea; logic [15:0] esr, sr;
    logic [1:0] pm; logic [31:0] lk; logic dc, uh; string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, failures = 0;

  logic [31:0] m_rpc = 32'h100, m_epc = 0, m_eea = 0, m_lk = '1;
  logic [15:0] m_esr = 0, m_sr = 16'h0001;
  logic [1:0]  m_pm = 0;

  function automatic string show(exp_t e);
    return $sformatf("rd=%0b rpc=%h epc=%h eea=%h esr=%h sr=%h pm=%0d lk=%h dc=%0b uh=%0b",
      e.rd, e.rpc, e.epc, e.eea, e.esr, e.sr, e.pm, e.lk, e.dc, e.uh);
  endfunction

  function automatic exp_t actual();
    exp_t a;
    a.rd = redirect; a.rpc = redirect_pc; a.epc = epc; a.eea = eea; a.esr = esr; a.sr = sr;
    a.pm = pm_en; a.lk = lock_addr; a.dc = dslot_clr; a.uh = unhandled; a.tag = "";
    return a;
  endfunction

  function automatic void compare(exp_t a, exp_t e);
    checks++;
    if (a.rd !== e.rd || a.rpc !== e.rpc || a.epc !== e.epc || a.eea !== e.eea ||
        a.esr !== e.esr || a.sr !== e.sr || a.pm !== e.pm || a.lk !== e.lk ||
        a.dc !== e.dc || a.uh !== e.uh) begin
      failures++;
      $display("FAIL %s actual {%s} expected {%s}", e.tag, show(a), show(e));
    end
  endfunction

  task automatic drive(input logic tk, input logic [3:0] c, input logic [31:0] pc, input logic ds,
                       input logic ie, input logic it, input logic vbe, input logic [31:0] evb,
                       input logic srl, input logic [15:0] srv, input logic pml, input logic [1:0] pmv,
                       input logic lks, input logic [31:0] lka, input string tag);
    exp_t e;
    logic vc, tok, eok, en;
    logic [3:0] ec;
    @(negedge clk);
    take = tk; cause = c; cur_pc = pc; in_dslot = ds; irq_ext = ie; irq_tick = it;
    vbar_en = vbe; evbar = evb; sr_load = srl; sr_load_val = srv; pm_load = pml;
    pm_load_val = pmv; lock_set = lks; lock_set_addr = lka;
    vc  = (c >= 1 && c <= 14);
    tok = it && m_sr[1];
    eok = ie && m_sr[2];
    en  = tk ? vc : (tok || eok);
    ec  = tk ? c : (tok ? 4'd5 : 4'd8);
    if (en) begin
      m_rpc = ({28'd0, ec} << 8) | (vbe ? evb : 32'd0) | (m_sr[5] ? 32'hF000_0000 : 32'd0);
      m_epc = pc + ((ec == 4'd12) ? 32'd4 : 32'd0) - (ds ? 32'd4 : 32'd0);
      if (ec == 4'd7) m_eea = pc;
      m_esr = m_sr;
      m_sr  = (m_sr & ~16'h005E) | 16'h0001 | (ds ? 16'h0040 : 16'h0000);
      m_pm  = 0;
      m_lk  = '1;
    end else begin
      if (srl) m_sr = srv;
      if (pml) m_pm = pmv;
      if (lks) m_lk = lka;
    end
    e.rd = en; e.rpc = m_rpc; e.epc = m_epc; e.eea = m_eea; e.esr = m_esr; e.sr = m_sr;
    e.pm = m_pm; e.lk = m_lk; e.dc = en && ds; e.uh = tk && !vc; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    take = 0; irq_ext = 0; irq_tick = 0; sr_load = 0; pm_load = 0; lock_set = 0; in_dslot = 0;
  endtask

  task automatic idle(input string tag);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic ld_sr(input logic [15:0] v, input string tag);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, v, 0, 0, 0, 0, tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (!rst && q.size() > 0) compare(actual(), q.pop_front());
  end

  initial begin
    exp_t r;
    repeat (3) @(negedge clk);
    r.rd = 0; r.rpc = 32'h100; r.epc = 0; r.eea = 0; r.esr = 0; r.sr = 16'h0001;
    r.pm = 0; r.lk = '1; r.dc = 0; r.uh = 0; r.tag = "R1 reset state";
    compare(actual(), r);
    rst = 0;
    @(negedge clk);
    r.tag = "R1 first cycle after reset";
    compare(actual(), r);

    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h001E, 1, 2'b11, 1, 32'h0000_1234, "R11 loads ahead of tests");
    drive(1, 4'd2, 32'h0000_1000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 R5 R6 R7 bus error entry");
    drive(1, 4'd12, 32'h0000_2000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 system call +4");
    drive(1, 4'd7, 32'h0000_3000, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 R4 illegal in delay slot");
    drive(1, 4'd12, 32'h0000_4000, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 system call in delay slot");
    drive(1, 4'd9, 32'h0000_5000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 R4 DSX cleared, eea kept");
    ld_sr(16'h0020, "R5 set high page bit");
    drive(1, 4'd6, 32'h0000_6000, 0, 0, 0, 1, 32'h0010_0000, 0, 0, 0, 0, 0, 0, "R7 base and high page");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2'b10, 1, 32'h0000_8888, "R6 reload pm and lock");
    drive(1, 4'd0, 32'h0000_7000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 cause 0 unhandled");
    drive(1, 4'd15, 32'h0000_7004, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 cause 15 unhandled");
    idle("R8 pulse ends");
    drive(0, 0, 32'h0000_9000, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 external ignored while disabled");
    ld_sr(16'h0004, "R9 enable external");
    drive(0, 0, 32'h0000_9000, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 external taken cause 8");
    ld_sr(16'h0004, "R10 enable external only");
    drive(0, 0, 32'h0000_9100, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R10 tick ignored while disabled");
    ld_sr(16'h0006, "R10 enable both");
    drive(0, 0, 32'h0000_A000, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R10 tick wins over external");
    ld_sr(16'h0006, "R11 enable both again");
    drive(1, 4'd3, 32'h0000_B000, 0, 1, 1, 0, 0, 1, 16'h0000, 1, 2'b01, 1, 32'h0000_0055, "R11 take wins");
    idle("R11 redirect pulse ends");
    idle("R11 drain");
    if (q.size() != 0) begin
      failures++;
      $display("FAIL R11 scoreboard left %0d items, expected 0", q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired, actual hung, expected finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule